// File: doc/BRIEF.md
# Two-Level Programmable Chip-Select Decoder

This block turns a 32-bit processor address into sixteen active-low chip selects. The selects are arranged as four groups of four. Each group owns a base and a mask register that place a coarse window in the address space. Each select owns a compare and a mask register that carve a sub-window out of its group window. A select fires only when both tests pass and the select is enabled. When several selects overlap, the lowest-numbered one wins, so at most one select is ever driven.

Each select carries its own port width (8 or 16 bits) and its own way of ending the cycle. It can count 0 to 6 internal wait cycles, or it can wait for an external acknowledge, which is first passed through a two-stage synchronizer. The block also drives a read output-enable and two byte-lane write enables. Select 0 of the first group comes out of reset already enabled and covering the whole address space, so a boot memory can be read before any software has run. A small write-only port loads the configuration.

Top module: `cs_group_decoder`

## Requirements
- R1: A select's output goes low in the cycle after `bus_as_n` is first sampled low, provided three conditions hold: the select is enabled, `((addr ^ group_base) & ~group_mask_eff) == 0`, and `((addr ^ sel_compare) & ~sel_mask_eff) == 0`. A miss in either test leaves every select high.
- R2: The effective masks of groups 0 and 1 (selects 0..7) always treat address bits [15:0] as don't-care. For groups 2 and 3 (selects 8..15) the don't-care bits are [11:0]. This applies to both the group mask and the select mask.
- R3: When several selects match, only the lowest-numbered one is driven, and no more than one `cs_n` bit is ever low. The chosen select is held until the address strobe is released.
- R4: After reset, all outputs are inactive: `cs_n` is all ones, all strobes are high, and `cyc_done` and `port_wide` are 0. Select 0 is enabled, matches every address, has a 16-bit port and uses 6 internal waits. Every other select is disabled.
- R5: In internal mode with a wait count W, `cyc_done` is a one-cycle pulse that appears W+1 cycles after the select first shows low. Writing a wait value of 7 stores 6.
- R6: In external mode the wait count is ignored. `cyc_done` pulses three cycles after `ext_ack_n` is first sampled low, because of the two synchronizer stages and one registered stage.
- R7: When `bus_as_n` is sampled high, all selects go high and `cyc_done` is 0 in the following cycle.
- R8: `oe_n` is low only while a select is active and `bus_rw`=1 (read).
- R9: For a 16-bit port write (`bus_rw`=0), `uwe_n` follows `bus_uds_n` and `lwe_n` follows `bus_lds_n` while a select is active.
- R10: For an 8-bit port write, `uwe_n` goes low if either data strobe is low, and `lwe_n` stays high. `port_wide` shows the width of the active select (1 = 16-bit).
- R11: Configuration map, written when `cfg_we`=1:
  - Group registers: `cfg_addr` = {1'b0, 3'b000, group[1:0], f}, where f=0 is the base and f=1 is the mask.
  - Select registers: `cfg_addr` = {1'b1, sel[3:0], f[1:0]}, where f=0 is the compare, f=1 is the mask and f=2 is the control word.
  - Control word bits: bit 0 enable, bit 1 16-bit port, bit 2 external acknowledge, bits [5:3] wait count.
- R12: A disabled select never asserts, even when its windows match. Enabling it later makes it respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| bus_addr | input | 32 | Processor address |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_uds_n | input | 1 | Upper data strobe, active low |
| bus_lds_n | input | 1 | Lower data strobe, active low |
| ext_ack_n | input | 1 | External transfer acknowledge, active low, asynchronous |
| cs_n | output | 16 | Chip selects, active low |
| cyc_done | output | 1 | One-cycle cycle-termination pulse |
| oe_n | output | 1 | Read output enable, active low |
| uwe_n | output | 1 | Upper byte write enable, active low |
| lwe_n | output | 1 | Lower byte write enable, active low |
| port_wide | output | 1 | Active select has a 16-bit port |

## Verification
The assertions check the following on every cycle: at most one select is low, the select choice is held while the strobe stays asserted, the done signal is a single pulse, a release returns the block to idle, stored wait counts stay within limit, and the byte strobes stay consistent with the read/write direction and the port width. Some behaviours can only be shown by the bench's scenarios, because they depend on programmed values:
- the window arithmetic, including the forced don't-care bits of each group class
- priority between overlapping selects
- the exact done latency for each wait count and for the external acknowledge path
- clamping of a written wait count of 7
- a select that is disabled and then enabled

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;
    localparam int ADDR_W      = 32;
    localparam int GROUPS      = 4;
    localparam int PER_GROUP   = 4;
    localparam int NUM_CS      = GROUPS * PER_GROUP;
    localparam int IDX_W       = $clog2(NUM_CS);
    localparam int GRP_W       = $clog2(GROUPS);
    localparam int WAIT_W      = 3;
    localparam int MAX_WAITS   = 6;
    localparam int BIG_GROUPS  = 2;
    localparam int BIG_GRAN    = 16;
    localparam int SMALL_GRAN  = 12;
    localparam int CFG_AW      = 1 + IDX_W + 2;
    localparam int SYNC_STAGES = 2;

    // control word fields
    localparam int CTL_EN       = 0;
    localparam int CTL_WIDE     = 1;
    localparam int CTL_EXT      = 2;
    localparam int CTL_WAIT_LSB = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } grp_cfg_t;

    typedef struct packed {
        logic              en;
        logic              wide;
        logic              ext;
        logic [WAIT_W-1:0] waits;
        logic [ADDR_W-1:0] cmp;
        logic [ADDR_W-1:0] mask;
    } sel_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_HOLD} cyc_state_t;

    // Low address bits that are always don't-care for a group class
    function automatic logic [ADDR_W-1:0] gran_mask(input int g);
        int bits;
        bits = (g < BIG_GROUPS) ? BIG_GRAN : SMALL_GRAN;
        return {ADDR_W{1'b1}} >> (ADDR_W - bits);
    endfunction

    function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] ref_v,
                                        input logic [ADDR_W-1:0] m);
        return ((a ^ ref_v) & ~m) == '0;
    endfunction

    function automatic logic [WAIT_W-1:0] clamp_waits(input logic [WAIT_W-1:0] v);
        return (v > WAIT_W'(MAX_WAITS)) ? WAIT_W'(MAX_WAITS) : v;
    endfunction
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_decode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output grp_cfg_t          grp_o [GROUPS],
    output sel_cfg_t          sel_o [NUM_CS]
);
    grp_cfg_t grp_q [GROUPS];
    sel_cfg_t sel_q [NUM_CS];

    logic            is_sel;
    logic [GRP_W-1:0] g_idx;
    logic [IDX_W-1:0] s_idx;
    logic [1:0]       s_fld;
    logic             g_pad_ok;

    assign is_sel   = cfg_addr[CFG_AW-1];
    assign g_idx    = cfg_addr[GRP_W:1];
    assign g_pad_ok = cfg_addr[CFG_AW-2:GRP_W+1] == '0;
    assign s_idx    = cfg_addr[IDX_W+1:2];
    assign s_fld    = cfg_addr[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GROUPS; g++) grp_q[g] <= '0;
            for (int n = 0; n < NUM_CS; n++) sel_q[n] <= '0;
            grp_q[0].mask <= '1;
            sel_q[0] <= '{en: 1'b1, wide: 1'b1, ext: 1'b0,
                          waits: WAIT_W'(MAX_WAITS), cmp: '0, mask: '1};
        end else if (cfg_we) begin
            if (!is_sel) begin
                if (g_pad_ok) begin
                    if (cfg_addr[0]) grp_q[g_idx].mask <= cfg_wdata;
                    else             grp_q[g_idx].base <= cfg_wdata;
                end
            end else begin
                case (s_fld)
                    2'd0: sel_q[s_idx].cmp  <= cfg_wdata;
                    2'd1: sel_q[s_idx].mask <= cfg_wdata;
                    2'd2: begin
                        sel_q[s_idx].en    <= cfg_wdata[CTL_EN];
                        sel_q[s_idx].wide  <= cfg_wdata[CTL_WIDE];
                        sel_q[s_idx].ext   <= cfg_wdata[CTL_EXT];
                        sel_q[s_idx].waits <= clamp_waits(cfg_wdata[CTL_WAIT_LSB +: WAIT_W]);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign grp_o = grp_q;
    assign sel_o = sel_q;

    generate
        for (genvar n = 0; n < NUM_CS; n++) begin : g_chk
            assert_waits_limit_R5: assert property (@(posedge clk) disable iff (rst)
                sel_q[n].waits <= WAIT_W'(MAX_WAITS));
        end
    endgenerate
endmodule

// File: rtl/cs_addr_match.sv
module cs_addr_match
    import cs_decode_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  grp_cfg_t          grp_i [GROUPS],
    input  sel_cfg_t          sel_i [NUM_CS],
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              hit_wide,
    output logic              hit_ext,
    output logic [WAIT_W-1:0] hit_waits
);
    logic [NUM_CS-1:0] match;

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            logic [ADDR_W-1:0] gm;
            logic              grp_ok;
            assign gm     = grp_i[g].mask | gran_mask(g);
            assign grp_ok = window_hit(addr, grp_i[g].base, gm);
            for (genvar s = 0; s < PER_GROUP; s++) begin : g_sel
                localparam int N = g * PER_GROUP + s;
                logic [ADDR_W-1:0] sm;
                assign sm       = sel_i[N].mask | gran_mask(g);
                assign match[N] = sel_i[N].en && grp_ok &&
                                  window_hit(addr, sel_i[N].cmp, sm);
            end
        end
    endgenerate

    // lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit_wide  = sel_i[hit_idx].wide;
    assign hit_ext   = sel_i[hit_idx].ext;
    assign hit_waits = sel_i[hit_idx].waits;
endmodule

// File: rtl/cs_cycle_ctrl.sv
module cs_cycle_ctrl
    import cs_decode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              rw,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              ext_ack_n,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic              hit_wide,
    input  logic              hit_ext,
    input  logic [WAIT_W-1:0] hit_waits,
    output logic [NUM_CS-1:0] cs_n,
    output logic              done,
    output logic              oe_n,
    output logic              uwe_n,
    output logic              lwe_n,
    output logic              port_wide
);
    cyc_state_t         state;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_wide;
    logic               sel_ext;
    logic [WAIT_W-1:0]  cnt;
    logic [SYNC_STAGES-1:0] ack_sync;
    logic               active;
    logic               wr_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sel_idx  <= '0;
            sel_wide <= 1'b0;
            sel_ext  <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_STAGES-2:0], ~ext_ack_n};
            done     <= 1'b0;
            if (as_n) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (hit) begin
                        state    <= ST_COUNT;
                        sel_idx  <= hit_idx;
                        sel_wide <= hit_wide;
                        sel_ext  <= hit_ext;
                        cnt      <= hit_waits;
                    end
                    ST_COUNT: begin
                        if (sel_ext) begin
                            if (ack_sync[SYNC_STAGES-1]) begin
                                done  <= 1'b1;
                                state <= ST_HOLD;
                            end
                        end else if (cnt == '0) begin
                            done  <= 1'b1;
                            state <= ST_HOLD;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign active    = state != ST_IDLE;
    assign wr_cyc    = active && !rw;
    assign cs_n      = active ? ~(NUM_CS'(1) << sel_idx) : '1;
    assign oe_n      = !(active && rw);
    assign uwe_n     = !(wr_cyc && (sel_wide ? !uds_n : (!uds_n || !lds_n)));
    assign lwe_n     = !(wr_cyc && sel_wide && !lds_n);
    assign port_wide = active && sel_wide;

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_release_idle_R7: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (state == ST_IDLE && !done));
    assert_sel_held_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !as_n) |=> $stable(sel_idx));
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= WAIT_W'(MAX_WAITS));
endmodule

// File: rtl/cs_group_decoder.sv
module cs_group_decoder
    import cs_decode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_as_n,
    input  logic              bus_rw,
    input  logic              bus_uds_n,
    input  logic              bus_lds_n,
    input  logic              ext_ack_n,
    output logic [NUM_CS-1:0] cs_n,
    output logic              cyc_done,
    output logic              oe_n,
    output logic              uwe_n,
    output logic              lwe_n,
    output logic              port_wide
);
    grp_cfg_t          grp_cfg [GROUPS];
    sel_cfg_t          sel_cfg [NUM_CS];
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              hit_wide;
    logic              hit_ext;
    logic [WAIT_W-1:0] hit_waits;

    cs_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .grp_o(grp_cfg), .sel_o(sel_cfg)
    );

    cs_addr_match u_match (
        .addr(bus_addr), .grp_i(grp_cfg), .sel_i(sel_cfg),
        .hit(hit), .hit_idx(hit_idx), .hit_wide(hit_wide),
        .hit_ext(hit_ext), .hit_waits(hit_waits)
    );

    cs_cycle_ctrl u_ctrl (
        .clk(clk), .rst(rst), .as_n(bus_as_n), .rw(bus_rw),
        .uds_n(bus_uds_n), .lds_n(bus_lds_n), .ext_ack_n(ext_ack_n),
        .hit(hit), .hit_idx(hit_idx), .hit_wide(hit_wide),
        .hit_ext(hit_ext), .hit_waits(hit_waits),
        .cs_n(cs_n), .done(cyc_done), .oe_n(oe_n), .uwe_n(uwe_n),
        .lwe_n(lwe_n), .port_wide(port_wide)
    );

    assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (bus_rw && !(&cs_n)));
    assert_lwe_wide_only_R10: assert property (@(posedge clk) disable iff (rst)
        !lwe_n |-> (port_wide && !bus_rw));
    assert_no_write_on_read_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rw |-> (uwe_n && lwe_n));
endmodule

// File: tb/test_cs_group_decoder.sv
module test_cs_group_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_as_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic        bus_uds_n = 1'b1;
    logic        bus_lds_n = 1'b1;
    logic        ext_ack_n = 1'b1;
    logic [15:0] cs_n;
    logic        cyc_done, oe_n, uwe_n, lwe_n, port_wide;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [15:0] cs;
        int          dly;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_group_decoder i_cs_group_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
        .bus_rw(bus_rw), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
        .ext_ack_n(ext_ack_n), .cs_n(cs_n), .cyc_done(cyc_done),
        .oe_n(oe_n), .uwe_n(uwe_n), .lwe_n(lwe_n), .port_wide(port_wide)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // R11 register map helpers
    function automatic logic [6:0] grp_reg(input int g, input int f);
        return 7'(g * 2 + f);
    endfunction
    function automatic logic [6:0] sel_reg(input int n, input int f);
        return 7'(64 + n * 4 + f);
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: one bus cycle, expected result pushed to the scoreboard
    task automatic access(input logic [31:0] a, input bit rd, input bit u_n,
                          input bit l_n, input int idx, input int dly,
                          input bit ext, input bit wide, input string req);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_rw = rd; bus_uds_n = u_n; bus_lds_n = l_n; bus_as_n = 1'b0;
        if (idx >= 0) begin
            e.cs = ~(16'd1 << idx); e.dly = dly; e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        if (idx < 0) begin
            chk(req, "no select", 32'(cs_n), 32'hFFFF);
        end else begin
            chk("R8",  "oe_n",      32'(oe_n),  32'(!rd ? 1 : 0));
            chk("R9",  "uwe_n",     32'(uwe_n), 32'(!(!rd && (wide ? !u_n : (!u_n || !l_n)))));
            chk("R9",  "lwe_n",     32'(lwe_n), 32'(!(!rd && wide && !l_n)));
            chk("R10", "port_wide", 32'(port_wide), 32'(wide));
        end
        if (ext) begin
            repeat (2) @(negedge clk);
            ext_ack_n = 1'b0;
            repeat (8) @(negedge clk);
        end else begin
            repeat (10) @(negedge clk);
        end
        bus_as_n = 1'b1; ext_ack_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1;
        @(negedge clk);
        chk("R7", "cs_n after release", 32'(cs_n), 32'hFFFF);
        chk("R7", "done after release", 32'(cyc_done), 32'h0);
        @(negedge clk);
    endtask

    // Monitor: pops expectations as selects appear and times cyc_done
    initial begin
        int   mstate = 0;
        int   elapsed = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            if (!rst) begin
                case (mstate)
                    0: if (!(&cs_n)) begin
                        if (exp_q.size() == 0) begin
                            chk("R1", "unexpected select", 32'(cs_n), 32'hFFFF);
                            mstate = 2;
                        end else begin
                            cur = exp_q.pop_front();
                            chk(cur.req, "cs_n", 32'(cs_n), 32'(cur.cs));
                            chk("R5", "done early", 32'(cyc_done), 32'h0);
                            elapsed = 0;
                            mstate = 1;
                        end
                    end
                    1: begin
                        elapsed++;
                        if (cyc_done) begin
                            chk(cur.req, "done latency", 32'(elapsed), 32'(cur.dly));
                            mstate = 2;
                        end else if (&cs_n) begin
                            chk(cur.req, "done missing", 32'(elapsed), 32'(cur.dly));
                            mstate = 0;
                        end
                    end
                    default: if (&cs_n) mstate = 0;
                endcase
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        chk("R4", "cs_n",      32'(cs_n),      32'hFFFF);
        chk("R4", "done",      32'(cyc_done),  32'h0);
        chk("R4", "oe_n",      32'(oe_n),      32'h1);
        chk("R4", "uwe_n",     32'(uwe_n),     32'h1);
        chk("R4", "lwe_n",     32'(lwe_n),     32'h1);
        chk("R4", "port_wide", 32'(port_wide), 32'h0);
        // R4 boot select covers any address, 6 waits, 16-bit
        access(32'h1234_5678, 1, 1, 1, 0, 7, 0, 1, "R4");

        // R11 configuration through the register map
        wr(grp_reg(0, 0), 32'h0000_0000);
        wr(grp_reg(0, 1), 32'h00FF_FFFF);
        wr(sel_reg(0, 0), 32'h0000_0000);
        wr(sel_reg(0, 1), 32'h000F_FFFF);
        wr(sel_reg(0, 2), 32'h13);          // en, wide, 2 waits
        wr(sel_reg(1, 0), 32'h0010_0000);
        wr(sel_reg(1, 1), 32'h000F_FFFF);
        wr(sel_reg(1, 2), 32'h01);          // en, 8-bit, 0 waits
        wr(sel_reg(2, 0), 32'h0000_0000);
        wr(sel_reg(2, 1), 32'h00FF_FFFF);
        wr(sel_reg(2, 2), 32'h0B);          // en, wide, 1 wait
        wr(grp_reg(1, 0), 32'h0100_0000);
        wr(grp_reg(1, 1), 32'h0000_0000);
        wr(sel_reg(4, 0), 32'h0100_0000);
        wr(sel_reg(4, 1), 32'h0000_0000);
        wr(sel_reg(4, 2), 32'h1F);          // en, wide, external, 3 waits
        wr(grp_reg(2, 0), 32'h8000_0000);
        wr(grp_reg(2, 1), 32'h0000_0000);
        wr(sel_reg(8, 0), 32'h8000_0000);
        wr(sel_reg(8, 1), 32'h0000_0000);
        wr(sel_reg(8, 2), 32'h03);          // en, wide, 0 waits
        wr(grp_reg(3, 0), 32'hC000_0000);
        wr(grp_reg(3, 1), 32'h0000_FFFF);
        wr(sel_reg(12, 0), 32'hC000_0000);
        wr(sel_reg(12, 1), 32'h0000_0FFF);
        wr(sel_reg(12, 2), 32'h02);         // disabled

        // R3 overlap of selects 0 and 2: lowest wins; R11 waits took effect
        access(32'h0000_0010, 1, 1, 1, 0, 3, 0, 1, "R3");
        // R9 16-bit writes
        access(32'h0000_0020, 0, 0, 1, 0, 3, 0, 1, "R9");
        access(32'h0000_0022, 0, 0, 0, 0, 3, 0, 1, "R9");
        access(32'h0000_0024, 0, 1, 0, 0, 3, 0, 1, "R9");
        // R10 8-bit write on select 1 (lower than overlapping select 2)
        access(32'h0010_0004, 0, 1, 0, 1, 1, 0, 0, "R10");
        // R3 only select 2 matches
        access(32'h0020_0000, 1, 1, 1, 2, 2, 0, 1, "R3");
        // R6 external acknowledge, wait count of 3 ignored; R2 low 16 bits free
        access(32'h0100_FFFE, 1, 1, 1, 4, 5, 1, 1, "R6");
        access(32'h0101_0000, 1, 1, 1, -1, 0, 0, 0, "R2");
        // R2 small groups: low 12 bits free only
        access(32'h8000_0ABC, 1, 1, 1, 8, 1, 0, 1, "R2");
        access(32'h8000_1000, 1, 1, 1, -1, 0, 0, 0, "R2");
        // R1 group window miss
        access(32'h0200_0000, 1, 1, 1, -1, 0, 0, 0, "R1");
        // R12 disabled select stays inactive
        access(32'hC000_0100, 1, 1, 1, -1, 0, 0, 0, "R12");
        // R5 wait value 7 clamps to 6; R12 now enabled
        wr(sel_reg(12, 2), 32'h3B);
        access(32'hC000_0100, 1, 1, 1, 12, 7, 0, 1, "R5");
        // R1 inside group window, outside select sub-window
        access(32'hC000_1000, 1, 1, 1, -1, 0, 0, 0, "R1");

        repeat (3) @(negedge clk);
        chk("R1", "unconsumed expectations", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule